// File: doc/BRIEF.md
# SPI Mailbox Command Sequencer

This block is an SPI host that hands a command and its argument words to a mailbox-style slave through a fixed chain of SPI transactions. A single `start` pulse captures a 24-bit command, two 24-bit argument words, two 24-bit follow-up words and the mode inputs. The block then writes the command block to the slave and waits until the slave reports that it has taken the values. If asked, it then performs one follow-up burst, either a write or a read. A follow-up write is followed by another acceptance wait. A follow-up read needs no wait.

Acceptance is detected in one of two ways, chosen per operation. In the first, the block issues short status-read transactions and tests bit 0 of the returned byte until it reads zero. In the second, it idles for a fixed time that is set as a parameter in microseconds and converted to clock cycles from the clock frequency. A poll budget stops an operation whose slave never clears its request bit. Bytes read back during a follow-up read are collected in an output register.

The controller moves through five named states. IDLE waits for `start`. SELECT holds select low for one SCK half period before the first bit. SHIFT moves bytes. SPACE holds select high between transactions. DELAY counts out the fixed wait. The transitions are:
- IDLE→SELECT on start.
- SELECT→SHIFT on the first half-period tick.
- SHIFT→SPACE after the last byte.
- SPACE→SELECT to begin a poll, the follow-up burst or a repeated poll.
- SPACE→DELAY after a write when fixed-delay mode is selected.
- DELAY→SELECT to begin the follow-up burst.
- SPACE→IDLE or DELAY→IDLE on finish or abort.

Top module: `mbx_cmd_seq`

## Requirements
- R1: After reset and while idle, `ss_n` is 1, `sck` is 0, and `busy`, `done` and `err` are 0. `sck` is never 1 while `ss_n` is 1.
- R2: The command transaction sends 11 bytes under one select, each byte MSB first in SPI mode 0 (SCK idles low, MOSI is stable at every rising edge). The bytes are 0x02, 0x03, then `cmd_word`, `data_a` and `data_b`, each word most significant byte first.
- R3: With `wait_fixed`=0, every write is followed by status transactions. Each status transaction sends 0x03, 0x01 and then 0x00 while one byte is read. Only bit 0 of the returned byte is tested. Status transactions repeat until that bit reads 0.
- R4: With `wait_fixed`=1, no status transactions are issued. At least DELAY_US·CLK_HZ/10^6 clock cycles pass after the end of each write before the next transaction or before `done`.
- R5: When `burst_en`=1 and `burst_rd`=0, a burst write follows acceptance of the command. It sends 0x02, 0x06, then `burst_a` and `burst_b`, each most significant byte first. It is followed by its own acceptance wait.
- R6: When `burst_en`=1 and `burst_rd`=1, a burst read follows acceptance of the command. It sends 0x03, 0x06 and six 0x00 bytes. The six returned bytes appear in `rd_data` with the first byte in bits 47:40. `done` follows within one inter-transaction spacing, without any wait.
- R7: Between consecutive transactions of one operation, `ss_n` stays high for at least two SCK periods (4·SCK_DIV clocks).
- R8: If POLL_MAX consecutive status reads return bit 0 = 1, the operation aborts. `err`=1 together with `done`, and no further transaction is issued. `err` is cleared by the next accepted `start`.
- R9: `busy` rises one cycle after an accepted `start` and falls in the cycle `done` pulses. `done` lasts exactly one cycle. `start` is ignored while `busy`=1, and all inputs are captured at the accepted `start`.
- R10: When `burst_en`=0, the operation ends after the command is accepted, whatever the value of `burst_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| wait_fixed | input | 1 | 1: fixed delay, 0: status polling |
| burst_en | input | 1 | Perform a follow-up burst |
| burst_rd | input | 1 | Follow-up burst direction (1 = read) |
| cmd_word | input | 24 | Command value |
| data_a | input | 24 | First argument word |
| data_b | input | 24 | Second argument word |
| burst_a | input | 24 | First follow-up write word |
| burst_b | input | 24 | Second follow-up write word |
| miso | input | 1 | Serial data from slave |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to slave |
| ss_n | output | 1 | Slave select, active low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll budget exhausted on the last operation |
| rd_data | output | 48 | Bytes captured by the follow-up read |

## Verification
The bench builds the block with CLK_HZ = 250 MHz, DELAY_US = 1, SCK_DIV = 2 and POLL_MAX = 5. This shrinks the fixed delay to 250 cycles and brings the poll-budget abort within reach after five status reads. A full command, status and burst sequence therefore fits in a few thousand cycles. The slave model in the bench can keep its request bit set for any number of polls. This exercises the early release, the multi-poll case and the abort. The fixed-delay runs measure the idle time after each write against 250 cycles.

// File: rtl/mbx_seq_pkg.sv
package mbx_seq_pkg;

    localparam int WORD_W  = 24;
    localparam int BYTE_W  = 8;
    localparam int IDX_W   = 4;

    localparam logic [7:0] OPC_WRITE = 8'h02;
    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] REG_CMD   = 8'h03;
    localparam logic [7:0] REG_STAT  = 8'h01;
    localparam logic [7:0] REG_DATA  = 8'h06;

    localparam logic [IDX_W-1:0] LEN_CMD  = 4'd11;
    localparam logic [IDX_W-1:0] LEN_STAT = 4'd3;
    localparam logic [IDX_W-1:0] LEN_DATA = 4'd8;

    typedef enum logic [1:0] {
        XF_CMD,
        XF_STAT,
        XF_BWR,
        XF_BRD
    } xfer_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_SHIFT,
        ST_SPACE,
        ST_DELAY
    } seq_state_e;

    function automatic logic [IDX_W-1:0] xfer_len(xfer_e x);
        logic [IDX_W-1:0] n;
        unique case (x)
            XF_CMD:  n = LEN_CMD;
            XF_STAT: n = LEN_STAT;
            default: n = LEN_DATA;
        endcase
        return n;
    endfunction

    function automatic logic [7:0] xfer_byte(xfer_e x, logic [IDX_W-1:0] idx,
                                             logic [3*WORD_W-1:0] cblk,
                                             logic [2*WORD_W-1:0] bblk);
        logic [7:0] b;
        int k;
        k = int'(idx) - 2;
        b = 8'h00;
        if (idx == '0)
            b = (x == XF_CMD || x == XF_BWR) ? OPC_WRITE : OPC_READ;
        else if (idx == 4'd1)
            b = (x == XF_CMD) ? REG_CMD : (x == XF_STAT) ? REG_STAT : REG_DATA;
        else if (x == XF_CMD && k >= 0 && k < 9)
            b = cblk[8*(8-k) +: 8];
        else if (x == XF_BWR && k >= 0 && k < 6)
            b = bblk[8*(5-k) +: 8];
        return b;
    endfunction

endpackage

// File: rtl/mbx_sck_tick.sv
module mbx_sck_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [W-1:0] LAST = W'(HALF - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en || cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/mbx_byte_shift.sv
module mbx_byte_shift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            load,
    input  logic [BITS-1:0] tx_byte,
    input  logic            miso,
    output logic            sck,
    output logic            mosi,
    output logic            done_p,
    output logic [BITS-1:0] rx_byte
);
    localparam int EW = $clog2(2*BITS);
    localparam logic [EW-1:0] LAST_EDGE = EW'(2*BITS - 1);

    logic [BITS-1:0] txs;
    logic [EW-1:0]   edges;
    logic            active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txs     <= '0;
            rx_byte <= '0;
            edges   <= '0;
            active  <= 1'b0;
            sck     <= 1'b0;
            mosi    <= 1'b0;
            done_p  <= 1'b0;
        end else if (load) begin
            txs    <= tx_byte;
            mosi   <= tx_byte[BITS-1];
            sck    <= 1'b0;
            edges  <= '0;
            active <= 1'b1;
            done_p <= 1'b0;
        end else begin
            done_p <= 1'b0;
            if (active && tick) begin
                edges <= edges + 1'b1;
                if (!sck) begin
                    sck     <= 1'b1;
                    rx_byte <= {rx_byte[BITS-2:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (edges == LAST_EDGE) begin
                        active <= 1'b0;
                        done_p <= 1'b1;
                    end else begin
                        mosi <= txs[BITS-2];
                        txs  <= {txs[BITS-2:0], 1'b0};
                    end
                end
            end
        end
    end

    // R2: data line never moves at a rising clock edge
    a_r2_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $stable(mosi));
endmodule

// File: rtl/mbx_cmd_seq.sv
module mbx_cmd_seq
    import mbx_seq_pkg::*;
#(
    parameter int CLK_HZ   = 100_000_000,
    parameter int DELAY_US = 1000,
    parameter int SCK_DIV  = 4,
    parameter int POLL_MAX = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        wait_fixed,
    input  logic        burst_en,
    input  logic        burst_rd,
    input  logic [23:0] cmd_word,
    input  logic [23:0] data_a,
    input  logic [23:0] data_b,
    input  logic [23:0] burst_a,
    input  logic [23:0] burst_b,
    input  logic        miso,
    output logic        sck,
    output logic        mosi,
    output logic        ss_n,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [47:0] rd_data
);
    localparam int DELAY_RAW = (CLK_HZ / 1_000_000) * DELAY_US;
    localparam int DELAY_CYC = (DELAY_RAW > 0) ? DELAY_RAW : 1;
    localparam int GAP_CYC   = 4 * SCK_DIV;
    localparam int CNT_MAX   = (DELAY_CYC > GAP_CYC) ? DELAY_CYC : GAP_CYC;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);
    localparam int PW        = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
    localparam logic [CNT_W-1:0] GAP_END   = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] DELAY_END = CNT_W'(DELAY_CYC - 1);
    localparam logic [PW-1:0]    POLL_END  = PW'(POLL_MAX - 1);

    seq_state_e state, state_d;
    xfer_e      xfer, xfer_d;
    logic       stage, stage_d;
    logic [PW-1:0] polls, polls_d;
    logic       fin, err_set, accept;

    logic [3*WORD_W-1:0] cmd_blk;
    logic [2*WORD_W-1:0] bw_blk;
    logic       fixed_q, ben_q, brd_q;
    logic [IDX_W-1:0] idx, nidx;
    logic [CNT_W-1:0] cnt;
    logic       stat_bit;

    logic       tick, load, sh_done, last_byte;
    logic [7:0] sh_rx, tx_byte;

    mbx_sck_tick #(.HALF(SCK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (state == ST_SELECT || state == ST_SHIFT),
        .tick (tick)
    );

    mbx_byte_shift #(.BITS(BYTE_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .load   (load),
        .tx_byte(tx_byte),
        .miso   (miso),
        .sck    (sck),
        .mosi   (mosi),
        .done_p (sh_done),
        .rx_byte(sh_rx)
    );

    assign last_byte = (idx == xfer_len(xfer) - 1'b1);
    assign nidx      = (state == ST_SELECT) ? '0 : idx + 1'b1;
    assign tx_byte   = xfer_byte(xfer, nidx, cmd_blk, bw_blk);
    assign load      = (state == ST_SELECT && tick) ||
                       (state == ST_SHIFT && sh_done && !last_byte);

    // next-state and transition decisions
    always_comb begin
        state_d = state;
        xfer_d  = xfer;
        stage_d = stage;
        polls_d = polls;
        fin     = 1'b0;
        err_set = 1'b0;
        accept  = 1'b0;
        unique case (state)
            ST_IDLE: if (start) begin
                state_d = ST_SELECT;
                xfer_d  = XF_CMD;
                stage_d = 1'b0;
            end
            ST_SELECT: if (tick) state_d = ST_SHIFT;
            ST_SHIFT:  if (sh_done && last_byte) state_d = ST_SPACE;
            ST_SPACE: if (cnt == GAP_END) begin
                unique case (xfer)
                    XF_CMD, XF_BWR: begin
                        stage_d = (xfer == XF_BWR);
                        polls_d = '0;
                        if (fixed_q) state_d = ST_DELAY;
                        else begin
                            xfer_d  = XF_STAT;
                            state_d = ST_SELECT;
                        end
                    end
                    XF_STAT: begin
                        if (!stat_bit) accept = 1'b1;
                        else if (polls == POLL_END) begin
                            err_set = 1'b1;
                            fin     = 1'b1;
                        end else begin
                            polls_d = polls + 1'b1;
                            state_d = ST_SELECT;
                        end
                    end
                    default: fin = 1'b1;
                endcase
            end
            ST_DELAY: if (cnt == DELAY_END) accept = 1'b1;
            default: state_d = ST_IDLE;
        endcase
        if (accept) begin
            if (!stage && ben_q) begin
                xfer_d  = brd_q ? XF_BRD : XF_BWR;
                state_d = ST_SELECT;
            end else begin
                fin = 1'b1;
            end
        end
        if (fin) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xfer     <= XF_CMD;
            stage    <= 1'b0;
            polls    <= '0;
            cmd_blk  <= '0;
            bw_blk   <= '0;
            fixed_q  <= 1'b0;
            ben_q    <= 1'b0;
            brd_q    <= 1'b0;
            idx      <= '0;
            cnt      <= '0;
            stat_bit <= 1'b0;
            rd_data  <= '0;
        end else begin
            xfer  <= xfer_d;
            stage <= stage_d;
            polls <= polls_d;
            if (state == ST_IDLE && start) begin
                cmd_blk <= {cmd_word, data_a, data_b};
                bw_blk  <= {burst_a, burst_b};
                fixed_q <= wait_fixed;
                ben_q   <= burst_en;
                brd_q   <= burst_rd;
            end
            if (load) idx <= nidx;
            if (state_d != state || !(state == ST_SPACE || state == ST_DELAY))
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
            if (state == ST_SHIFT && sh_done && xfer == XF_STAT && idx == 4'd2)
                stat_bit <= sh_rx[0];
            if (state == ST_SHIFT && sh_done && xfer == XF_BRD && idx >= 4'd2)
                rd_data <= {rd_data[39:0], sh_rx};
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ss_n <= 1'b1;
            busy <= 1'b0;
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            ss_n <= !(state_d == ST_SELECT || state_d == ST_SHIFT);
            busy <= (state_d != ST_IDLE);
            done <= fin;
            if (state == ST_IDLE && start) err <= 1'b0;
            else if (err_set)              err <= 1'b1;
        end
    end

    // spacing monitor for the select-high assertion
    logic [CNT_W-1:0] hi_cnt;
    logic             hi_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt  <= '0;
            hi_seen <= 1'b0;
        end else begin
            if (!ss_n)                           hi_cnt <= '0;
            else if (hi_cnt < CNT_W'(GAP_CYC))   hi_cnt <= hi_cnt + 1'b1;
            if (!busy)      hi_seen <= 1'b0;
            else if (!ss_n) hi_seen <= 1'b1;
        end
    end

    a_r7_select_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ss_n) && hi_seen) |-> (hi_cnt >= CNT_W'(GAP_CYC)));
    a_r1_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> !sck);
    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_select_in_op: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_n |-> busy);
    a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);
endmodule

// File: tb/tb_mbx_cmd_seq.sv
`timescale 1ns/1ps
module tb_mbx_cmd_seq;
    localparam int CLK_HZ    = 250_000_000;
    localparam int DELAY_US  = 1;
    localparam int SCK_DIV   = 2;
    localparam int POLL_MAX  = 5;
    localparam int DELAY_CYC = (CLK_HZ / 1_000_000) * DELAY_US;
    localparam int GAP_CYC   = 4 * SCK_DIV;
    localparam int WATCHDOG  = 100_000;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic wait_fixed = 1'b0, burst_en = 1'b0, burst_rd = 1'b0;
    logic [23:0] cmd_word = '0, data_a = '0, data_b = '0, burst_a = '0, burst_b = '0;
    logic miso = 1'b0;
    logic sck, mosi, ss_n, busy, done, err;
    logic [47:0] rd_data;

    mbx_cmd_seq #(.CLK_HZ(CLK_HZ), .DELAY_US(DELAY_US), .SCK_DIV(SCK_DIV),
                  .POLL_MAX(POLL_MAX)) dut (.*);

    always #2 clk = ~clk;

    int cyc = 0;
    always @(negedge clk) cyc++;

    int n_chk = 0, n_bad = 0;
    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected transaction list
    logic [7:0] exp_b[$];
    int         exp_n[$];
    string      exp_t[$];

    task automatic push_word(logic [23:0] w);
        exp_b.push_back(w[23:16]); exp_b.push_back(w[15:8]); exp_b.push_back(w[7:0]);
    endtask
    task automatic exp_cmd(logic [23:0] c, logic [23:0] a, logic [23:0] b);
        exp_b.push_back(8'h02); exp_b.push_back(8'h03);
        push_word(c); push_word(a); push_word(b);
        exp_n.push_back(11); exp_t.push_back("R2 command transaction");
    endtask
    task automatic exp_poll();
        exp_b.push_back(8'h03); exp_b.push_back(8'h01); exp_b.push_back(8'h00);
        exp_n.push_back(3); exp_t.push_back("R3 status transaction");
    endtask
    task automatic exp_bw(logic [23:0] x, logic [23:0] y);
        exp_b.push_back(8'h02); exp_b.push_back(8'h06);
        push_word(x); push_word(y);
        exp_n.push_back(8); exp_t.push_back("R5 burst write");
    endtask
    task automatic exp_br();
        exp_b.push_back(8'h03); exp_b.push_back(8'h06);
        for (int i = 0; i < 6; i++) exp_b.push_back(8'h00);
        exp_n.push_back(8); exp_t.push_back("R6 burst read");
    endtask

    // behavioural slave
    logic [7:0] rxb [0:15];
    logic [7:0] br_pat [0:5];
    logic [7:0] sh = '0, osr = '0, ob;
    int  nb = 0, bc = 0, pend = 0, busy_polls = 0;
    bit  in_x = 0, fixed_mode = 0, wr_pending = 0, op_seen = 0;
    int  wr_end = 0, last_rise = 0;

    always @(negedge ss_n) begin
        in_x = 1; nb = 0; bc = 0;
        if (op_seen) chk(cyc - last_rise >= GAP_CYC, "R7 select spacing", cyc - last_rise, GAP_CYC);
        if (wr_pending && fixed_mode)
            chk(cyc - wr_end >= DELAY_CYC, "R4 delay before next transaction", cyc - wr_end, DELAY_CYC);
        wr_pending = 0;
        op_seen = 1;
    end

    always @(posedge sck) if (!ss_n) begin
        sh = {sh[6:0], mosi};
        bc++;
        if (bc == 8) begin
            if (nb < 16) rxb[nb] = sh;
            nb++;
            bc = 0;
        end
    end

    always @(negedge sck) if (!ss_n) begin
        if (bc == 0) begin
            ob = 8'h00;
            if (nb >= 2 && rxb[0] == 8'h03 && rxb[1] == 8'h01 && nb == 2) begin
                ob = {7'h52, pend > 0};
                if (pend > 0) pend--;
            end else if (nb >= 2 && nb < 8 && rxb[0] == 8'h03 && rxb[1] == 8'h06)
                ob = br_pat[nb-2];
            miso = ob[7];
            osr  = {ob[6:0], 1'b0};
        end else begin
            miso = osr[7];
            osr  = {osr[6:0], 1'b0};
        end
    end

    always @(posedge ss_n) if (in_x) begin
        int n;
        string t;
        bit ok;
        logic [7:0] fa, fe;
        in_x = 0;
        if (exp_n.size() == 0) begin
            chk(0, "R9 unexpected transaction", nb, 0);
        end else begin
            n = exp_n.pop_front();
            t = exp_t.pop_front();
            ok = (nb == n);
            fa = 8'(nb); fe = 8'(n);
            for (int i = 0; i < n; i++) begin
                logic [7:0] e;
                e = exp_b.pop_front();
                if (ok && i < nb && i < 16 && rxb[i] != e) begin
                    ok = 0; fa = rxb[i]; fe = e;
                end
            end
            chk(ok, t, fa, fe);
        end
        if (nb > 0 && rxb[0] == 8'h02) begin
            pend = busy_polls;
            wr_end = cyc;
            wr_pending = 1;
        end
        last_rise = cyc;
    end

    // per-clock monitor
    bit mon_on = 0, prev_busy = 0;
    int done_cnt = 0;
    always @(negedge clk) if (mon_on) begin
        #1;
        chk(!(ss_n && sck), "R1 sck low while deselected", sck, 0);
        if (done) begin
            done_cnt++;
            chk(!busy, "R9 busy low with done", busy, 0);
        end
        if (prev_busy && !busy) chk(done, "R9 busy falls with done", done, 1);
        prev_busy = busy;
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    int done_cyc;
    task automatic run_op(bit fx, bit ben, bit brd, logic [23:0] c, logic [23:0] a,
                          logic [23:0] b, logic [23:0] x, logic [23:0] y, int bp, bit inject);
        wait_fixed = fx; burst_en = ben; burst_rd = brd;
        cmd_word = c; data_a = a; data_b = b; burst_a = x; burst_b = y;
        busy_polls = bp; fixed_mode = fx; wr_pending = 0; op_seen = 0;
        start = 1; step(); start = 0;
        chk(busy, "R9 busy after start", busy, 1);
        if (inject) begin
            repeat (40) step();
            cmd_word = 24'hDEAD01; wait_fixed = ~fx; burst_en = 1;
            start = 1; step(); start = 0;
        end
        while (!done) step();
        done_cyc = cyc;
        chk(exp_n.size() == 0, "R2 all expected transactions seen", exp_n.size(), 0);
        if (wr_pending && fx)
            chk(done_cyc - wr_end >= DELAY_CYC, "R4 delay before done", done_cyc - wr_end, DELAY_CYC);
        wr_pending = 0;
        step();
        chk(!done, "R9 done single cycle", done, 0);
    endtask

    initial begin
        for (int i = 0; i < 6; i++) br_pat[i] = 8'(8'h3C + 8'h17 * i);
        repeat (3) step();
        chk(ss_n === 1'b1 && sck === 1'b0, "R1 reset lines", {ss_n, sck}, 2'b10);
        chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1 reset status", {busy, done, err}, 0);
        rst_n = 1; step(); mon_on = 1;
        repeat (3) step();
        chk(ss_n && !busy, "R1 idle after reset", {ss_n, busy}, 2'b10);

        // R3 + R10: polled, no burst, two busy replies
        exp_cmd(24'h123456, 24'hABCDEF, 24'h0F1E2D);
        exp_poll(); exp_poll(); exp_poll();
        run_op(0, 0, 1, 24'h123456, 24'hABCDEF, 24'h0F1E2D, 24'h111111, 24'h222222, 2, 0);
        chk(!err, "R10 clean finish without burst", err, 0);

        // R5: polled burst write
        exp_cmd(24'h800001, 24'h7FFFFE, 24'hC3A55A);
        exp_poll(); exp_poll();
        exp_bw(24'h9A8B7C, 24'h010203);
        exp_poll(); exp_poll();
        run_op(0, 1, 0, 24'h800001, 24'h7FFFFE, 24'hC3A55A, 24'h9A8B7C, 24'h010203, 1, 0);
        chk(!err, "R5 no error", err, 0);

        // R4 + R6: fixed delay, burst read
        exp_cmd(24'h00FF00, 24'h55AA55, 24'h000001);
        exp_br();
        run_op(1, 1, 1, 24'h00FF00, 24'h55AA55, 24'h000001, 24'h0, 24'h0, 0, 0);
        chk(rd_data == {br_pat[0], br_pat[1], br_pat[2], br_pat[3], br_pat[4], br_pat[5]},
            "R6 read data", rd_data,
            {br_pat[0], br_pat[1], br_pat[2], br_pat[3], br_pat[4], br_pat[5]});
        chk(done_cyc - last_rise <= GAP_CYC + 3, "R6 no wait after read", done_cyc - last_rise, GAP_CYC + 3);

        // R4 + R5: fixed delay, burst write
        exp_cmd(24'hFEDCBA, 24'h000000, 24'hFFFFFF);
        exp_bw(24'h13579B, 24'h2468AC);
        run_op(1, 1, 0, 24'hFEDCBA, 24'h000000, 24'hFFFFFF, 24'h13579B, 24'h2468AC, 3, 0);

        // R8: slave never releases
        exp_cmd(24'h0BAD00, 24'h000010, 24'h000020);
        for (int i = 0; i < POLL_MAX; i++) exp_poll();
        run_op(0, 1, 0, 24'h0BAD00, 24'h000010, 24'h000020, 24'h333333, 24'h444444, 100, 0);
        chk(err, "R8 error on poll budget", err, 1);
        repeat (60) step();
        chk(exp_n.size() == 0 && ss_n && !busy, "R8 nothing after abort", {ss_n, busy}, 2'b10);

        // R9: start ignored while busy, err cleared
        done_cnt = 0;
        exp_cmd(24'h246810, 24'h0A0B0C, 24'hD0E0F0);
        exp_poll();
        run_op(0, 0, 0, 24'h246810, 24'h0A0B0C, 24'hD0E0F0, 24'h0, 24'h0, 0, 1);
        chk(!err, "R8 error cleared by new start", err, 0);
        repeat (80) step();
        chk(done_cnt == 1 && !busy, "R9 single done, no restart", done_cnt, 1);

        mon_on = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc >= WATCHDOG);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule